// File: doc/BRIEF.md
# Snooping Invalidate-Based Line State Controller

This block keeps the coherence state of every line of one direct-mapped cache that shares a single bus with other caches. Each line is Invalid, Shared (clean, possibly also held elsewhere) or Modified (dirty, held only here). Processor reads and writes arrive on one port. Transactions that other caches place on the bus arrive on a second, snoop, port. The block decides when it must own the bus, and it issues the bus commands that keep all copies consistent.

A processor access that cannot finish locally raises a bus request and waits for the grant. When the grant arrives, the block checks the line state again, because a snoop may have changed it during the wait. It then issues a dirty-victim write-back if one is needed, followed by one fill or invalidate command. Each command stays on the bus until the bus acknowledges it. Snoop lookups use a second copy of the tags, so they run alongside processor lookups. The processor side waits only when both ports touch the same line index in the same cycle. In that cycle the snoop is applied first.

A snooped miss that hits a dirty local line makes the block supply a write-back and drop the line to Invalid. The line does not stay Shared. Every local read miss is filled from memory, even when another cache holds a copy. The data array, the arbiter and memory lie outside this block.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 0), and `cpu_stall`, `cpu_done`, `bus_req` and `snp_flush` are low, so the first access to any line misses.
- R2: A read that hits a Shared (code 1) or Modified (code 2) line makes no bus request, and `cpu_done` rises two cycles after the request cycle.
- R3: A read that misses with a clean or Invalid victim issues one read-miss command (code 1) for the line-aligned address, and the line becomes Shared.
- R4: A miss whose victim line is Modified first issues a write-back (code 4) of the victim's line address, then the fill command.
- R5: A write that hits a Modified line makes no bus request and completes in two cycles.
- R6: A write that hits a Shared line issues one invalidate command (code 3), and the line becomes Modified.
- R7: A write that misses issues a write-miss command (code 2), preceded by a write-back if the victim is Modified, and the line becomes Modified.
- R8: A snooped read miss (code 1) or write miss (code 2) that hits a Modified line pulses `snp_flush` one cycle later with the line-aligned address, and the line becomes Invalid.
- R9: A snooped write miss or invalidate (code 3) that hits a Shared line makes it Invalid. A snooped read miss that hits a Shared line leaves it Shared.
- R10: A snoop whose tag does not match the stored tag has no effect on the line state and does not flush.
- R11: When a snoop and a pending processor lookup touch the same index in one cycle, the snoop update is applied first and the lookup waits one cycle.
- R12: `cpu_stall` stays high from acceptance until the `cpu_done` cycle. A bus command and its address hold steady until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle access request, accepted when `cpu_stall` is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address: offset, then index, then tag |
| cpu_stall | output | 1 | Access in progress |
| cpu_done | output | 1 | One-cycle pulse when the access completes |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership granted |
| bus_cmd | output | 3 | Command: 0 none, 1 read miss, 2 write miss, 3 invalidate, 4 write-back |
| bus_addr | output | ADDR_W | Line-aligned address of the command |
| bus_ack | input | 1 | Current command has completed |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 3 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | Pulse: the local dirty copy is written back |
| snp_flush_addr | output | ADDR_W | Line-aligned address of the flushed line |

## Verification
The in-RTL assertions check, on every cycle, that a bus command and its address hold until acknowledged, that a stall never ends without a done pulse, that a write-back only goes out while the line is still dirty, that a flush only follows a matching snoop, and that a snoop write to the state array wins over a processor write to the same line. Which command sequence each access produces, and how every snoop moves a line between states, can only be seen through the bench's scenarios. The bench sweeps every line index through all state-and-operation pairs. It also runs same-index and different-index collisions between a snoop and a lookup, and it tracks the expected state of every line in its own model.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_MOD = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    BC_NONE   = 3'd0,
    BC_RDMISS = 3'd1,
    BC_WRMISS = 3'd2,
    BC_INVAL  = 3'd3,
    BC_WBACK  = 3'd4
  } bus_cmd_e;

  typedef enum logic [2:0] {
    P_IDLE, P_LOOK, P_ARB, P_WB, P_XFER, P_DONE
  } cpu_ph_e;
endpackage

// File: rtl/coh_tag_ram.sv
module coh_tag_ram #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [TAG_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [TAG_W-1:0] rdata
);
  logic [TAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/coh_line_state.sv
module coh_line_state
  import coh_pkg::*;
#(
  parameter int LINES = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_a_idx,
  output line_st_e         rd_a_st,
  input  logic [IDX_W-1:0] rd_b_idx,
  output line_st_e         rd_b_st,
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  line_st_e         a_st,
  input  logic             b_we,
  input  logic [IDX_W-1:0] b_idx,
  input  line_st_e         b_st
);
  line_st_e st_q [LINES];

  // port b (snoop) is written last so it wins on a shared index
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
    end else begin
      if (a_we) st_q[a_idx] <= a_st;
      if (b_we) st_q[b_idx] <= b_st;
    end
  end

  assign rd_a_st = st_q[rd_a_idx];
  assign rd_b_st = st_q[rd_b_idx];

  assert_snoop_priority_R11: assert property (@(posedge clk) disable iff (rst)
    b_we |=> st_q[$past(b_idx)] == $past(b_st));

  assert_cpu_write_R3: assert property (@(posedge clk) disable iff (rst)
    (a_we && !(b_we && b_idx == a_idx)) |=> st_q[$past(a_idx)] == $past(a_st));
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  bus_cmd_e          snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  output logic [IDX_W-1:0]  snp_idx,
  output logic              st_we,
  output line_st_e          st_new,
  output logic              flush,
  output logic [ADDR_W-1:0] flush_addr
);
  logic [TAG_W-1:0] snp_tag;
  logic             hit, dirty_take;

  assign snp_idx = snp_addr[OFF_W +: IDX_W];
  assign snp_tag = snp_addr[ADDR_W-1 -: TAG_W];
  assign hit     = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);
  assign dirty_take = hit && (line_st == LS_MOD) &&
                      ((snp_cmd == BC_RDMISS) || (snp_cmd == BC_WRMISS));

  always_comb begin
    st_we  = 1'b0;
    st_new = LS_INV;
    if (hit) begin
      unique case (snp_cmd)
        BC_RDMISS: st_we = (line_st == LS_MOD);
        BC_WRMISS: st_we = 1'b1;
        BC_INVAL:  st_we = 1'b1;
        default:   st_we = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flush      <= 1'b0;
      flush_addr <= '0;
    end else begin
      flush      <= dirty_take;
      flush_addr <= {snp_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end
  end

  assert_flush_cause_R8: assert property (@(posedge clk) disable iff (rst)
    flush |-> ($past(snp_valid) && $past(snp_cmd) != BC_INVAL &&
               $past(snp_cmd) != BC_NONE));
endmodule

// File: rtl/coh_cpu_fsm.sv
module coh_cpu_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-OFF_W-1:0] cpu_line,
  input  logic              bus_gnt,
  input  logic              bus_ack,
  input  logic              snp_valid,
  input  logic [IDX_W-1:0]  snp_idx,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  output logic [IDX_W-1:0]  req_idx,
  output logic              st_we,
  output line_st_e          st_new,
  output logic              tag_we,
  output logic [TAG_W-1:0]  tag_wdata,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic              bus_req,
  output bus_cmd_e          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr
);
  localparam int LINE_W = ADDR_W - OFF_W;

  cpu_ph_e             ph_q;
  logic                we_q;
  logic [LINE_W-1:0]   line_q;
  logic [TAG_W-1:0]    req_tag;
  logic                conflict, tag_match, hit, fast, need_wb;
  bus_cmd_e            miss_cmd;

  assign req_idx   = line_q[IDX_W-1:0];
  assign req_tag   = line_q[LINE_W-1 -: TAG_W];
  assign conflict  = snp_valid && (snp_idx == req_idx);
  assign tag_match = (line_tag == req_tag);
  assign hit       = (line_st != LS_INV) && tag_match;
  assign fast      = hit && (!we_q || line_st == LS_MOD);
  assign need_wb   = (line_st == LS_MOD) && !tag_match;
  assign miss_cmd  = we_q ? BC_WRMISS : BC_RDMISS;

  always_comb begin
    st_we  = 1'b0;
    st_new = LS_INV;
    if (ph_q == P_WB && bus_ack) begin
      st_we  = 1'b1;
      st_new = LS_INV;
    end else if (ph_q == P_XFER && bus_ack) begin
      st_we  = 1'b1;
      st_new = we_q ? LS_MOD : LS_SHR;
    end
  end

  assign tag_we    = (ph_q == P_XFER) && bus_ack;
  assign tag_wdata = req_tag;
  assign cpu_stall = (ph_q != P_IDLE);
  assign cpu_done  = (ph_q == P_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= P_IDLE;
      we_q     <= 1'b0;
      line_q   <= '0;
      bus_req  <= 1'b0;
      bus_cmd  <= BC_NONE;
      bus_addr <= '0;
    end else begin
      unique case (ph_q)
        P_IDLE: if (cpu_req) begin
          we_q   <= cpu_we;
          line_q <= cpu_line;
          ph_q   <= P_LOOK;
        end
        P_LOOK: if (!conflict) begin
          if (fast) ph_q <= P_DONE;
          else begin
            bus_req <= 1'b1;
            ph_q    <= P_ARB;
          end
        end
        P_ARB: if (bus_gnt && !conflict) begin
          if (need_wb) begin
            bus_cmd  <= BC_WBACK;
            bus_addr <= {line_tag, req_idx, {OFF_W{1'b0}}};
            ph_q     <= P_WB;
          end else if (!hit) begin
            bus_cmd  <= miss_cmd;
            bus_addr <= {line_q, {OFF_W{1'b0}}};
            ph_q     <= P_XFER;
          end else if (!fast) begin
            bus_cmd  <= BC_INVAL;
            bus_addr <= {line_q, {OFF_W{1'b0}}};
            ph_q     <= P_XFER;
          end else begin
            bus_req <= 1'b0;
            ph_q    <= P_DONE;
          end
        end
        P_WB: if (bus_ack) begin
          bus_cmd  <= miss_cmd;
          bus_addr <= {line_q, {OFF_W{1'b0}}};
          ph_q     <= P_XFER;
        end
        P_XFER: if (bus_ack) begin
          bus_cmd <= BC_NONE;
          bus_req <= 1'b0;
          ph_q    <= P_DONE;
        end
        P_DONE: ph_q <= P_IDLE;
        default: ph_q <= P_IDLE;
      endcase
    end
  end

  assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != BC_NONE && !bus_ack) |=> ($stable(bus_cmd) && $stable(bus_addr)));

  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (cpu_stall && !cpu_done) |=> cpu_stall);

  assert_done_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> (bus_cmd == BC_NONE && !bus_req));

  assert_wb_dirty_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == BC_WBACK) |-> (line_st == LS_MOD));
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINES  = 16,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ack,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush,
  output logic [ADDR_W-1:0] snp_flush_addr
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int COPIES = 2;  // 0: processor lookups, 1: snoop lookups

  logic [IDX_W-1:0] req_idx, snp_idx;
  logic             cpu_st_we, snp_st_we, tag_we;
  line_st_e         cpu_st_new, snp_st_new, cpu_line_st, snp_line_st;
  logic [TAG_W-1:0] tag_wdata;
  logic [IDX_W-1:0] trd_idx [COPIES];
  logic [TAG_W-1:0] trd_tag [COPIES];
  bus_cmd_e         bus_cmd_w;
  logic             unused_off;

  assign unused_off = ^cpu_addr[OFF_W-1:0];
  assign trd_idx[0] = req_idx;
  assign trd_idx[1] = snp_idx;

  for (genvar g = 0; g < COPIES; g++) begin : g_tagcopy
    coh_tag_ram #(.DEPTH(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
      .clk(clk), .we(tag_we), .waddr(req_idx), .wdata(tag_wdata),
      .raddr(trd_idx[g]), .rdata(trd_tag[g]));
  end

  coh_line_state #(.LINES(LINES), .IDX_W(IDX_W)) u_state (
    .clk(clk), .rst(rst),
    .rd_a_idx(req_idx), .rd_a_st(cpu_line_st),
    .rd_b_idx(snp_idx), .rd_b_st(snp_line_st),
    .a_we(cpu_st_we), .a_idx(req_idx), .a_st(cpu_st_new),
    .b_we(snp_st_we), .b_idx(snp_idx), .b_st(snp_st_new));

  coh_snoop_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoop (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)),
    .snp_addr(snp_addr), .line_st(snp_line_st), .line_tag(trd_tag[1]),
    .snp_idx(snp_idx), .st_we(snp_st_we), .st_new(snp_st_new),
    .flush(snp_flush), .flush_addr(snp_flush_addr));

  coh_cpu_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_cpu (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_line(cpu_addr[ADDR_W-1:OFF_W]), .bus_gnt(bus_gnt), .bus_ack(bus_ack),
    .snp_valid(snp_valid), .snp_idx(snp_idx), .line_st(cpu_line_st),
    .line_tag(trd_tag[0]), .req_idx(req_idx), .st_we(cpu_st_we),
    .st_new(cpu_st_new), .tag_we(tag_we), .tag_wdata(tag_wdata),
    .cpu_stall(cpu_stall), .cpu_done(cpu_done), .bus_req(bus_req),
    .bus_cmd(bus_cmd_w), .bus_addr(bus_addr));

  assign bus_cmd = bus_cmd_w;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!cpu_stall && !bus_req && !snp_flush));
endmodule

// File: tb/sim_snoop_coh_ctrl.sv
module sim_snoop_coh_ctrl;
  localparam int AW = 16;
  localparam int OFFB = 3;
  localparam int IDXB = 4;
  localparam int NL = 16;

  logic clk = 0, rst = 1;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_stall, cpu_done, bus_req, snp_flush;
  logic bus_gnt = 0, bus_ack = 0;
  logic [2:0] bus_cmd;
  logic [AW-1:0] bus_addr, snp_flush_addr;
  logic snp_valid = 0;
  logic [2:0] snp_cmd = 0;
  logic [AW-1:0] snp_addr = '0;

  int errors = 0, checks = 0, cyc = 0;
  int exp_st [NL];
  int exp_tag [NL];
  int log_cmd [8];
  int log_addr [8];
  int log_n = 0, ack_cnt = 0;
  bit bus_seen = 0;

  always #5 clk = ~clk;

  snoop_coh_ctrl #(.ADDR_W(AW), .LINES(NL), .WORDS(8)) u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_stall(cpu_stall), .cpu_done(cpu_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_ack(bus_ack), .snp_valid(snp_valid),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_flush(snp_flush),
    .snp_flush_addr(snp_flush_addr));

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired: actual=%0d expected<=150000", cyc);
      summary();
      $finish;
    end
  end

  // bus and memory responder: grant one cycle after request, ack after two
  always @(negedge clk) begin
    if (bus_req) bus_seen = 1;
    if (!bus_req) begin
      bus_gnt = 0; bus_ack = 0; ack_cnt = 0;
    end else if (!bus_gnt) begin
      bus_gnt = 1;
    end else if (bus_ack) begin
      bus_ack = 0; ack_cnt = 0;
    end else if (bus_cmd != 0) begin
      ack_cnt++;
      if (ack_cnt == 2) begin
        if (log_n < 8) begin
          log_cmd[log_n] = int'(bus_cmd);
          log_addr[log_n] = int'(bus_addr);
        end
        log_n++;
        bus_ack = 1;
      end
    end
  end

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int mk(int tag, int idx);
    return (tag << (OFFB + IDXB)) | (idx << OFFB);
  endfunction

  // model of a snoop; returns 1 when a flush is expected
  function automatic bit model_snp(int cmd, int tag, int idx);
    bit h = (exp_st[idx] != 0) && (exp_tag[idx] == tag);
    if (!h) return 0;
    if (exp_st[idx] == 2 && (cmd == 1 || cmd == 2)) begin
      exp_st[idx] = 0; return 1;
    end
    if (cmd == 2 || cmd == 3) exp_st[idx] = 0;
    return 0;
  endfunction

  task automatic snoop(int cmd, int tag, int idx, string rq);
    bit ef;
    @(negedge clk);
    while (cpu_stall) @(negedge clk);
    snp_valid = 1; snp_cmd = 3'(cmd); snp_addr = AW'(mk(tag, idx) | 5);
    @(negedge clk);
    snp_valid = 0;
    ef = model_snp(cmd, tag, idx);
    chk(snp_flush == ef, rq, "flush pulse", int'(snp_flush), int'(ef));
    if (ef) chk(int'(snp_flush_addr) == mk(tag, idx), rq, "flush address",
                int'(snp_flush_addr), mk(tag, idx));
  endtask

  task automatic cpu_op(bit we, int tag, int idx, bit inj, int icmd, int itag, int iidx,
                        string rq);
    int ec [2]; int ea [2]; int en = 0; int n; bit h; bit dummy;
    @(negedge clk);
    while (cpu_stall) @(negedge clk);
    log_n = 0; bus_seen = 0;
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(mk(tag, idx) | 3);
    @(negedge clk);
    cpu_req = 0; n = 1;
    if (inj) begin
      snp_valid = 1; snp_cmd = 3'(icmd); snp_addr = AW'(mk(itag, iidx));
      dummy = model_snp(icmd, itag, iidx);
    end
    while (!cpu_done && n < 400) begin
      @(negedge clk); n++; snp_valid = 0;
    end
    h = (exp_st[idx] != 0) && (exp_tag[idx] == tag);
    if (h && (!we || exp_st[idx] == 2)) en = 0;
    else if (h) begin ec[0] = 3; ea[0] = mk(tag, idx); en = 1; end
    else begin
      if (exp_st[idx] == 2) begin ec[en] = 4; ea[en] = mk(exp_tag[idx], idx); en++; end
      ec[en] = we ? 2 : 1; ea[en] = mk(tag, idx); en++;
    end
    if (!h || we) begin exp_st[idx] = we ? 2 : 1; exp_tag[idx] = tag; end
    chk(cpu_done == 1'b1, rq, "completion", int'(cpu_done), 1);
    chk(log_n == en, rq, "bus command count", log_n, en);
    for (int k = 0; k < en && k < log_n; k++) begin
      chk(log_cmd[k] == ec[k], rq, "bus command code", log_cmd[k], ec[k]);
      chk(log_addr[k] == ea[k], rq, "bus address", log_addr[k], ea[k]);
    end
    if (en == 0) begin
      int el = (inj && iidx == idx) ? 3 : 2;
      chk(!bus_seen, rq, "no bus request on hit", int'(bus_seen), 0);
      chk(n == el, rq, "hit latency", n, el);
    end
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin exp_st[i] = 0; exp_tag[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!cpu_stall && !cpu_done && !bus_req && !snp_flush, "R1", "idle after reset",
        int'({cpu_stall, cpu_done, bus_req, snp_flush}), 0);

    for (int i = 0; i < NL; i++) begin
      int ta = i + 1, tb = i + 17, tc = i + 40;
      cpu_op(0, ta, i, 0, 0, 0, 0, "R1");       // first read misses: R3 too
      cpu_op(0, ta, i, 0, 0, 0, 0, "R2");
      snoop(1, ta, i, "R9");
      cpu_op(0, ta, i, 0, 0, 0, 0, "R9");
      snoop(3, tc, i, "R10");
      cpu_op(1, ta, i, 0, 0, 0, 0, "R6");
      cpu_op(1, ta, i, 0, 0, 0, 0, "R5");
      snoop(2, tc, i, "R10");
      cpu_op(0, ta, i, 0, 0, 0, 0, "R10");
      cpu_op(0, tb, i, 0, 0, 0, 0, "R4");
      snoop(2, tb, i, "R9");
      cpu_op(1, tb, i, 0, 0, 0, 0, "R7");
      cpu_op(1, tc, i, 0, 0, 0, 0, "R7");
      snoop(1, tc, i, "R8");
      cpu_op(0, tc, i, 0, 0, 0, 0, "R3");
      snoop(3, tc, i, "R9");
      cpu_op(0, tc, i, 0, 0, 0, 0, "R3");
      cpu_op(1, tc, i, 0, 0, 0, 0, "R6");
      snoop(2, tc, i, "R8");
      cpu_op(1, ta, i, 0, 0, 0, 0, "R7");
    end

    // collisions between a pending lookup and a snoop
    cpu_op(0, 5, 2, 0, 0, 0, 0, "R3");
    cpu_op(0, 5, 2, 1, 1, 5, 2, "R11");   // same index, no state change: one-cycle wait
    cpu_op(0, 5, 2, 1, 2, 5, 2, "R11");   // same index, snoop kills the line first
    cpu_op(0, 5, 2, 1, 3, 9, 3, "R11");   // other index: no wait
    cpu_op(1, 5, 2, 0, 0, 0, 0, "R6");
    cpu_op(0, 5, 2, 1, 1, 5, 2, "R11");   // same index on a dirty line: read now misses
    cpu_op(1, 7, 4, 0, 0, 0, 0, "R12");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule